// File: doc/BRIEF.md
# Staggered Fan Power-On Sequencer

This block brings up six fan-enable outputs one at a time after the main supply reports ready, so the fans never start together and the inrush is spread out. While the supply-ready input is low, every output is held off. Once it is high, the block walks a fixed, non-numeric order of fans. Before each fan it waits an interval, then turns that fan on. The fan stays on until the supply drops or the sequence is restarted.

The length of each wait scales with that fan's programmed 3-bit divisor code. The interval is a base tick count multiplied by 2 raised to the code, which gives a factor of 1 to 128. With the default base count, a 250 MHz clock and every code set to 1 (divide by 2), the full six-step bring-up lasts about 71.5 ms. A done flag rises together with the sixth enable. All inputs and outputs are plain control levels. There is no streaming data path, so no valid/ready handshake applies.

Top module: `fan_power_sequencer`

## Requirements
- R1: While `supply_ok` is low at a rising clock edge, `fan_en` is all zeros and `seq_done` is low after that edge. Both outputs are also low during `rst_n` low.
- R2: No more than one `fan_en` bit turns on at any single clock edge.
- R3: Fans turn on in the order 6, 2, 3, 1, 4, 5. Bit i of `fan_en` drives fan number i+1.
- R4: Each step waits BASE_TICKS × 2^code clock edges with supply high, where code is the divisor of the fan about to turn on. The divisor of fan n is `div_codes[3(n-1)+2 : 3(n-1)]`. The first fan turns on at the edge that completes its interval, counted from the first edge at which `supply_ok` is sampled high.
- R5: A fan that has been turned on stays on as long as `supply_ok` stays high and `init` stays low.
- R6: `seq_done` rises at the same edge as the sixth enable. It stays high, with all six fans on, until reset, `init` or a supply drop.
- R7: If `supply_ok` falls mid-sequence, all outputs clear and the step count returns to zero. The next rise of `supply_ok` replays the whole sequence with full intervals.
- R8: `init` sampled high at an edge clears all outputs after that edge. The sequence then starts again from the first fan at the first edge with `init` low.
- R9: A divisor code is read live. If it is changed mid-step so that the new interval is already used up, the pending fan turns on at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous restart of the sequence |
| supply_ok | input | 1 | Main supply ready level |
| div_codes | input | 18 | Three-bit divisor code per fan, fan 1 in the low bits |
| fan_en | output | 6 | Fan enables, bit i is fan i+1 |
| seq_done | output | 1 | All six fans have been enabled |

## Verification
A fan enable is due at the edge that closes the running sum of intervals, counted from the first edge at which supply is sampled high. The bench keeps a count of the edges since that point and samples on the falling edge one cycle before and at that sum. There it expects the enable mask to lack and then to include the next fan in the order. A supply drop or an `init` pulse takes effect one edge later and is checked at the following falling edge. A mid-step shrink of a divisor is expected to fire at the very next edge.

// File: rtl/fan_seq_pkg.sv
package fan_seq_pkg;
  localparam int NUM_FANS = 6;
  localparam int CODE_W   = 3;
  localparam int STEP_W   = 3;

  // Position in the bring-up order -> fan bit index (bit i is fan i+1).
  function automatic logic [2:0] order_idx(input logic [2:0] pos);
    case (pos)
      3'd0:    order_idx = 3'd5;
      3'd1:    order_idx = 3'd1;
      3'd2:    order_idx = 3'd2;
      3'd3:    order_idx = 3'd0;
      3'd4:    order_idx = 3'd3;
      3'd5:    order_idx = 3'd4;
      default: order_idx = 3'd0;
    endcase
  endfunction

  // Mask of fans that come before the given fan bit in the order.
  function automatic logic [5:0] prereq_mask(input int fan);
    logic [5:0] m;
    logic       hit;
    m   = '0;
    hit = 1'b0;
    for (int p = 0; p < NUM_FANS; p++) begin
      if (int'(order_idx(3'(p))) == fan) hit = 1'b1;
      if (!hit) m[order_idx(3'(p))] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/fan_div_select.sv
module fan_div_select
  import fan_seq_pkg::*;
#(
  parameter int N_FANS = NUM_FANS,
  parameter int CW     = CODE_W
) (
  input  logic [N_FANS*CW-1:0] div_codes,
  input  logic [STEP_W-1:0]    step,
  output logic [CW-1:0]        code,
  output logic [2:0]           sel_fan
);
  int base;

  always_comb begin
    sel_fan = order_idx(step);
    base    = int'(sel_fan) * CW;
    if (int'(step) < N_FANS) code = div_codes[base +: CW];
    else                     code = '0;
  end
endmodule

// File: rtl/fan_step_timer.sv
module fan_step_timer #(
  parameter int BASE_TICKS = 1489583,
  parameter int CW         = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  input  logic [CW-1:0] code,
  output logic          fire
);
  localparam int MAX_SHIFT    = (1 << CW) - 1;
  localparam int MAX_INTERVAL = BASE_TICKS * (2 ** MAX_SHIFT);
  localparam int CNT_W        = $clog2(MAX_INTERVAL + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] interval;

  always_comb begin
    interval = CNT_W'(BASE_TICKS) << code;
    fire     = run && !clear && (cnt >= interval - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (clear || !run || fire) cnt <= '0;
    else                           cnt <= cnt + CNT_W'(1);
  end

  // R4: the wait counter never runs past the longest legal interval
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < MAX_INTERVAL);

  // R1/R8: the counter is held at zero after a cleared cycle
  assert_cnt_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt == '0);
endmodule

// File: rtl/fan_enable_bank.sv
module fan_enable_bank
  import fan_seq_pkg::*;
#(
  parameter int N_FANS = NUM_FANS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              fire,
  input  logic              last,
  input  logic [2:0]        sel_fan,
  output logic [N_FANS-1:0] fan_en,
  output logic              seq_done
);
  for (genvar i = 0; i < N_FANS; i++) begin : g_fan
    localparam logic [5:0] PRE = prereq_mask(i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              fan_en[i] <= 1'b0;
      else if (clear)                          fan_en[i] <= 1'b0;
      else if (fire && int'(sel_fan) == i)     fan_en[i] <= 1'b1;
    end

    // R3: a fan only comes on once every fan ahead of it is on
    assert_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fan_en[i]) |-> ((6'(fan_en) & PRE) == PRE));

    // R5: an enabled fan stays on while not cleared
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fan_en[i] && !clear) |=> fan_en[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            seq_done <= 1'b0;
    else if (clear)        seq_done <= 1'b0;
    else if (fire && last) seq_done <= 1'b1;
  end

  // R2: at most one new enable per edge
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fan_en & ~$past(fan_en)));

  // R6: done implies the full set is on
  assert_done_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (&fan_en));
endmodule

// File: rtl/fan_power_sequencer.sv
module fan_power_sequencer
  import fan_seq_pkg::*;
#(
  parameter int BASE_TICKS = 1489583
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       init,
  input  logic                       supply_ok,
  input  logic [NUM_FANS*CODE_W-1:0] div_codes,
  output logic [NUM_FANS-1:0]        fan_en,
  output logic                       seq_done
);
  logic [STEP_W-1:0] step;
  logic [CODE_W-1:0] code;
  logic [2:0]        sel_fan;
  logic              clear, run, fire, last;

  always_comb begin
    clear = init || !supply_ok;
    run   = int'(step) < NUM_FANS;
    last  = int'(step) == NUM_FANS - 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     step <= '0;
    else if (clear) step <= '0;
    else if (fire)  step <= step + STEP_W'(1);
  end

  fan_div_select #(.N_FANS(NUM_FANS), .CW(CODE_W)) u_sel (
    .div_codes (div_codes),
    .step      (step),
    .code      (code),
    .sel_fan   (sel_fan)
  );

  fan_step_timer #(.BASE_TICKS(BASE_TICKS), .CW(CODE_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .run   (run),
    .code  (code),
    .fire  (fire)
  );

  fan_enable_bank #(.N_FANS(NUM_FANS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .fire     (fire),
    .last     (last),
    .sel_fan  (sel_fan),
    .fan_en   (fan_en),
    .seq_done (seq_done)
  );

  // R1: supply low forces every output off at the next edge
  assert_off_without_supply_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (fan_en == '0 && !seq_done));

  // R8: init clears the outputs
  assert_init_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (fan_en == '0 && !seq_done));

  // R6: step count never passes the fan count
  assert_step_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(step) <= NUM_FANS);
endmodule

// File: tb/tb_fan_power_sequencer.sv
`timescale 1ns/1ps
module tb_fan_power_sequencer;
  localparam int BASE = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init = 1'b0;
  logic        supply_ok = 1'b0;
  logic [17:0] div_codes = '0;
  logic [5:0]  fan_en;
  logic        seq_done;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  fan_power_sequencer #(.BASE_TICKS(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .init(init), .supply_ok(supply_ok),
    .div_codes(div_codes), .fan_en(fan_en), .seq_done(seq_done)
  );

  // fan number (1..6) enabled at position k
  function automatic int fan_at(input int k);
    int ord[6] = '{6, 2, 3, 1, 4, 5};
    return ord[k];
  endfunction

  function automatic int interval_of(input logic [17:0] codes, input int fan);
    return BASE * (1 << codes[3*(fan-1) +: 3]);
  endfunction

  function automatic logic [5:0] mask_upto(input int k);
    logic [5:0] m = '0;
    for (int j = 0; j < k; j++) m[fan_at(j)-1] = 1'b1;
    return m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at a negedge; raises supply (clears init) and checks every step.
  task automatic run_seq(input logic [17:0] codes);
    int elapsed = 0;
    int cum = 0;
    div_codes = codes;
    supply_ok = 1'b1;
    init = 1'b0;
    for (int k = 0; k < 6; k++) begin
      cum += interval_of(codes, fan_at(k));
      adv(cum - 1 - elapsed);
      chk("R4 before step", 32'(fan_en), 32'(mask_upto(k)));
      chk("R6 done early", 32'(seq_done), 32'(0));
      adv(1);
      elapsed = cum;
      chk("R3 order mask", 32'(fan_en), 32'(mask_upto(k+1)));
      chk("R6 done at sixth", 32'(seq_done), 32'(k == 5));
    end
  endtask

  task automatic drop_supply();
    supply_ok = 1'b0;
    adv(2);
  endtask

  initial begin
    #(4ns * 150000);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [17:0] rc;
    void'($urandom(32'd4217));
    adv(3);
    chk("R1 reset fan_en", 32'(fan_en), 32'(0));
    chk("R1 reset done", 32'(seq_done), 32'(0));
    rst_n = 1'b1;
    adv(20);
    chk("R1 supply low", 32'(fan_en), 32'(0));

    // default divisor 1 on all fans
    run_seq({6{3'd1}});
    adv(40);
    chk("R6 done held", 32'(seq_done), 32'(1));
    chk("R5 fans held", 32'(fan_en), 32'h3F);
    drop_supply();
    chk("R7 cleared after done", 32'(fan_en), 32'(0));

    // supply drop mid-sequence, then full replay
    div_codes = {6{3'd1}};
    supply_ok = 1'b1;
    adv(15);
    chk("R5 partial", 32'(fan_en), 32'(mask_upto(2)));
    supply_ok = 1'b0;
    adv(1);
    chk("R7 drop clears", 32'(fan_en), 32'(0));
    chk("R7 drop done", 32'(seq_done), 32'(0));
    adv(20);
    chk("R1 stays off", 32'(fan_en), 32'(0));
    run_seq({3'd2, 3'd0, 3'd1, 3'd3, 3'd0, 3'd2});
    drop_supply();

    // init restart
    div_codes = {6{3'd1}};
    supply_ok = 1'b1;
    adv(13);
    chk("R5 before init", 32'(fan_en), 32'(mask_upto(2)));
    init = 1'b1;
    adv(1);
    chk("R8 init clears", 32'(fan_en), 32'(0));
    run_seq({6{3'd1}});
    drop_supply();

    // live divisor shrink: fan 6 code 0, fan 2 code 7
    supply_ok = 1'b1;
    div_codes = 18'd0;
    div_codes[3*1 +: 3] = 3'd7;
    adv(3);
    chk("R4 first fan", 32'(fan_en), 32'h20);
    adv(100);
    chk("R9 not yet", 32'(fan_en), 32'h20);
    div_codes[3*1 +: 3] = 3'd0;
    adv(1);
    chk("R9 fires next edge", 32'(fan_en), 32'h22);
    chk("R2 one step", 32'(fan_en & ~6'h20), 32'h02);
    drop_supply();

    // constrained random divisors 0..5
    for (int t = 0; t < 6; t++) begin
      rc = '0;
      for (int f = 0; f < 6; f++) rc[3*f +: 3] = 3'($urandom % 6);
      run_seq(rc);
      drop_supply();
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule